// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recent virtual-page to physical-page translations and answers lookups against all of them at once. A lookup presents a virtual page number and, in the same cycle, gets back a hit flag, the physical page number, a one-hot vector naming the matching slot, and an error flag raised when two or more slots match.

Misses are not handled in hardware. Control code refills the cache itself. To support that, the block offers three helpers. The first is a victim pointer that names the slot the next write will fill. The second is a global invalidate and a per-page invalidate. The third is a probe address generator. That generator folds a virtual page number into a table index, adds a programmable base, and steps to the next slot on each retry, so software can search a hashed translation table in memory.

Top module: `xlat_cache`

## Requirements
- R1: When a valid slot holds the presented lookup page, `lk_hit` is 1 in the same cycle, `lk_match` bit i is 1 for slot i, and `lk_ppn` carries that slot's physical page. With no matching slot, `lk_hit` is 0 and `lk_match` is all zero.
- R2: A write with `wr_en` fills slot `victim_idx` and marks it valid. On the next cycle `victim_idx` has advanced by one and wraps from ENTRIES-1 to 0. A write may evict an older translation, which then misses.
- R3: `victim_idx` changes only on an accepted write. Lookups, per-page invalidates and idle cycles leave it unchanged.
- R4: When more than one valid slot matches the lookup page, `lk_multi` is 1, `lk_hit` is 1, and `lk_ppn` is the bitwise OR of the matching slots' physical pages.
- R5: `inv_all` clears every slot by the next cycle. It takes priority over a write in the same cycle: that write is discarded and `victim_idx` holds.
- R6: `inv_one` clears every slot whose page equals `inv_vpn` and leaves the others. A write in the same cycle is still installed in its own slot, even when it carries the same page.
- R7: After reset, no lookup hits, `victim_idx` is 0, and `pr_addr` is 0.
- R8: `pr_start` loads the table index with the XOR fold of `pr_vpn`. Bit j of the index is the XOR of every page bit i with i mod TIDX_W = j. From the next cycle, `pr_addr` equals base + index * 2^TENT_SHIFT, modulo 2^PA_W.
- R9: Each `pr_retry` cycle adds one to the table index, modulo 2^TIDX_W. When `pr_start` and `pr_retry` are both 1 in the same cycle, `pr_start` wins.
- R10: `base_we` loads `base_val` into the table base, and `pr_addr` reflects the new base from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page of the matching slot(s) |
| lk_match | output | ENTRIES | Per-slot match vector |
| lk_multi | output | 1 | More than one slot matched |
| wr_en | input | 1 | Install a translation at the victim slot |
| wr_vpn | input | VPN_W | Virtual page to install |
| wr_ppn | input | PPN_W | Physical page to install |
| victim_idx | output | $clog2(ENTRIES) | Slot the next write fills |
| inv_all | input | 1 | Clear all slots |
| inv_one | input | 1 | Clear slots holding inv_vpn |
| inv_vpn | input | VPN_W | Page to invalidate |
| base_we | input | 1 | Load table base |
| base_val | input | PA_W | New table base |
| pr_start | input | 1 | Start a probe from pr_vpn |
| pr_vpn | input | VPN_W | Page to hash for the probe |
| pr_retry | input | 1 | Step the probe to the next table slot |
| pr_addr | output | PA_W | Current probe address |

## Verification
The assertions check several rules on every cycle. The victim pointer advances by one with wrap on each accepted write and holds otherwise. A global invalidate leaves no hit on the following cycle, whatever page is looked up. A just-written page, looked up on the next cycle, hits with its own physical page unless a duplicate exists. A multi-match never comes without a hit. The bench scenarios are needed for the rest: eviction after the pointer wraps, the OR-merged page on duplicates, the per-page invalidate racing a write, and the exact hashed probe addresses, including the index wrap and the case where start beats retry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Default geometry of the translation cache
    localparam int XL_ENTRIES    = 16;
    localparam int XL_VPN_W      = 20;
    localparam int XL_PPN_W      = 20;
    localparam int XL_PA_W       = 32;
    localparam int XL_TIDX_W     = 8;
    localparam int XL_TENT_SHIFT = 3;

    // Operation applied to the probe index register in a cycle
    typedef enum logic [1:0] {
        PROBE_HOLD = 2'd0,
        PROBE_LOAD = 2'd1,
        PROBE_STEP = 2'd2
    } probe_op_e;

    // Operation applied to one cache slot in a cycle
    typedef enum logic [1:0] {
        SLOT_KEEP  = 2'd0,
        SLOT_CLEAR = 2'd1,
        SLOT_FILL  = 2'd2
    } slot_op_e;

    // Picks the probe operation: a fresh start beats a retry
    function automatic probe_op_e probe_decode(input logic start, input logic retry);
        if (start)
            return PROBE_LOAD;
        else if (retry)
            return PROBE_STEP;
        else
            return PROBE_HOLD;
    endfunction

    // Picks the slot operation: flush, then fill, then page kill
    function automatic slot_op_e slot_decode(input logic flush, input logic fill,
                                             input logic kill);
        if (flush)
            return SLOT_CLEAR;
        else if (fill)
            return SLOT_FILL;
        else if (kill)
            return SLOT_CLEAR;
        else
            return SLOT_KEEP;
    endfunction

endpackage

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
    import xlat_pkg::*;
#(
    parameter int ENTRIES = XL_ENTRIES,
    parameter int VPN_W   = XL_VPN_W,
    parameter int PPN_W   = XL_PPN_W,
    localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic               flush,
    input  logic               kill_en,
    input  logic [VPN_W-1:0]   kill_vpn,
    input  logic               fill_en,
    input  logic [SEL_W-1:0]   fill_sel,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    output logic [ENTRIES-1:0] match,
    output logic [PPN_W-1:0]   ppn_merged
);

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } slot_t;

    logic [PPN_W-1:0] ppn_gated [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        slot_t    slot_q;
        slot_op_e op;

        assign op = slot_decode(flush,
                                fill_en && (fill_sel == SEL_W'(g)),
                                kill_en && slot_q.valid && (slot_q.vpn == kill_vpn));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else begin
                case (op)
                    SLOT_CLEAR: slot_q.valid <= 1'b0;
                    SLOT_FILL:  slot_q <= '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn};
                    default:    slot_q <= slot_q;
                endcase
            end
        end

        assign match[g]     = slot_q.valid && (slot_q.vpn == lk_vpn);
        assign ppn_gated[g] = match[g] ? slot_q.ppn : '0;
    end

    always_comb begin
        ppn_merged = '0;
        for (int i = 0; i < ENTRIES; i++)
            ppn_merged |= ppn_gated[i];
    end

endmodule

// File: rtl/xlat_victim_ptr.sv
module xlat_victim_ptr
    import xlat_pkg::*;
#(
    parameter int ENTRIES = XL_ENTRIES,
    localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam logic [SEL_W-1:0] LAST = SEL_W'(ENTRIES - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [SEL_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (advance)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/xlat_probe_gen.sv
module xlat_probe_gen
    import xlat_pkg::*;
#(
    parameter int VPN_W      = XL_VPN_W,
    parameter int PA_W       = XL_PA_W,
    parameter int TIDX_W     = XL_TIDX_W,
    parameter int TENT_SHIFT = XL_TENT_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_we,
    input  logic [PA_W-1:0]  base_val,
    input  logic             start,
    input  logic [VPN_W-1:0] vpn,
    input  logic             retry,
    output logic [PA_W-1:0]  addr
);

    // Bit j collects every page bit whose position is j modulo TIDX_W
    function automatic logic [TIDX_W-1:0] fold_vpn(input logic [VPN_W-1:0] v);
        logic [TIDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < VPN_W; i++)
            r[i % TIDX_W] ^= v[i];
        return r;
    endfunction

    logic [PA_W-1:0]   base_q;
    logic [TIDX_W-1:0] idx_q;
    probe_op_e         op;

    assign op = probe_decode(start, retry);

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (base_we)
            base_q <= base_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else begin
            case (op)
                PROBE_LOAD: idx_q <= fold_vpn(vpn);
                PROBE_STEP: idx_q <= idx_q + 1'b1;
                default:    idx_q <= idx_q;
            endcase
        end
    end

    assign addr = base_q + (PA_W'(idx_q) << TENT_SHIFT);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES    = XL_ENTRIES,
    parameter int VPN_W      = XL_VPN_W,
    parameter int PPN_W      = XL_PPN_W,
    parameter int PA_W       = XL_PA_W,
    parameter int TIDX_W     = XL_TIDX_W,
    parameter int TENT_SHIFT = XL_TENT_SHIFT,
    localparam int SEL_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [PPN_W-1:0]   lk_ppn,
    output logic [ENTRIES-1:0] lk_match,
    output logic               lk_multi,
    input  logic               wr_en,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    output logic [SEL_W-1:0]   victim_idx,
    input  logic               inv_all,
    input  logic               inv_one,
    input  logic [VPN_W-1:0]   inv_vpn,
    input  logic               base_we,
    input  logic [PA_W-1:0]    base_val,
    input  logic               pr_start,
    input  logic [VPN_W-1:0]   pr_vpn,
    input  logic               pr_retry,
    output logic [PA_W-1:0]    pr_addr
);

    // A write is dropped when a global flush shares its cycle
    logic wr_accept;
    assign wr_accept = wr_en && !inv_all;

    xlat_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .lk_vpn     (lk_vpn),
        .flush      (inv_all),
        .kill_en    (inv_one),
        .kill_vpn   (inv_vpn),
        .fill_en    (wr_accept),
        .fill_sel   (victim_idx),
        .fill_vpn   (wr_vpn),
        .fill_ppn   (wr_ppn),
        .match      (lk_match),
        .ppn_merged (lk_ppn)
    );

    xlat_victim_ptr #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk     (clk),
        .rst     (rst),
        .advance (wr_accept),
        .ptr     (victim_idx)
    );

    xlat_probe_gen #(
        .VPN_W      (VPN_W),
        .PA_W       (PA_W),
        .TIDX_W     (TIDX_W),
        .TENT_SHIFT (TENT_SHIFT)
    ) u_probe (
        .clk      (clk),
        .rst      (rst),
        .base_we  (base_we),
        .base_val (base_val),
        .start    (pr_start),
        .vpn      (pr_vpn),
        .retry    (pr_retry),
        .addr     (pr_addr)
    );

    assign lk_hit   = |lk_match;
    assign lk_multi = ($countones(lk_match) > 1);

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_hit,
    input logic [PPN_W-1:0] lk_ppn,
    input logic             lk_multi,
    input logic             wr_en,
    input logic [VPN_W-1:0] wr_vpn,
    input logic [PPN_W-1:0] wr_ppn,
    input logic [SEL_W-1:0] victim_idx,
    input logic             inv_all
);

    // R2
    victim_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inv_all) |=> victim_idx ==
            (($past(victim_idx) == SEL_W'(ENTRIES - 1)) ? '0 : $past(victim_idx) + 1'b1));

    // R3
    victim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !inv_all) |=> $stable(victim_idx));

    // R5
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> !lk_hit);

    // R1
    write_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inv_all) ##1 (lk_vpn == $past(wr_vpn) && !lk_multi)
            |-> (lk_hit && lk_ppn == $past(wr_ppn)));

    // R4
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> lk_hit);

endmodule

bind xlat_cache xlat_cache_chk #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
) u_chk (.*);

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;

    localparam int ENTRIES = 16;
    localparam int VPN_W   = 20;
    localparam int PPN_W   = 20;
    localparam int PA_W    = 32;
    localparam int TIDX_W  = 8;
    localparam int TSHIFT  = 3;
    localparam int SEL_W   = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [VPN_W-1:0]   lk_vpn = '0;
    logic               lk_hit;
    logic [PPN_W-1:0]   lk_ppn;
    logic [ENTRIES-1:0] lk_match;
    logic               lk_multi;
    logic               wr_en = 1'b0;
    logic [VPN_W-1:0]   wr_vpn = '0;
    logic [PPN_W-1:0]   wr_ppn = '0;
    logic [SEL_W-1:0]   victim_idx;
    logic               inv_all = 1'b0;
    logic               inv_one = 1'b0;
    logic [VPN_W-1:0]   inv_vpn = '0;
    logic               base_we = 1'b0;
    logic [PA_W-1:0]    base_val = '0;
    logic               pr_start = 1'b0;
    logic [VPN_W-1:0]   pr_vpn = '0;
    logic               pr_retry = 1'b0;
    logic [PA_W-1:0]    pr_addr;

    always #2.5 clk = ~clk;

    xlat_cache u_dut (
        .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .lk_match(lk_match), .lk_multi(lk_multi), .wr_en(wr_en), .wr_vpn(wr_vpn),
        .wr_ppn(wr_ppn), .victim_idx(victim_idx), .inv_all(inv_all), .inv_one(inv_one),
        .inv_vpn(inv_vpn), .base_we(base_we), .base_val(base_val), .pr_start(pr_start),
        .pr_vpn(pr_vpn), .pr_retry(pr_retry), .pr_addr(pr_addr)
    );

    // Scoreboard items: which output, the expected value, and the requirement
    typedef enum int {K_HIT, K_PPN, K_MATCH, K_MULTI, K_VIC, K_ADDR} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;

    // Reference state built from the requirements
    bit               m_valid [ENTRIES];
    logic [VPN_W-1:0] m_vpn   [ENTRIES];
    logic [PPN_W-1:0] m_ppn   [ENTRIES];
    int               m_ptr = 0;
    logic [PA_W-1:0]  m_base = '0;
    logic [TIDX_W-1:0] m_idx = '0;

    function automatic logic [TIDX_W-1:0] hash_ref(input logic [VPN_W-1:0] v);
        logic [TIDX_W-1:0] r = '0;
        for (int c = 0; c < VPN_W; c += TIDX_W)
            r ^= TIDX_W'(v >> c);
        return r;
    endfunction

    task automatic push(input kind_e k, input logic [31:0] e, input string t);
        item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        q.push_back(it);
    endtask

    // Monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_HIT:   act = 32'(lk_hit);
                    K_PPN:   act = 32'(lk_ppn);
                    K_MATCH: act = 32'(lk_match);
                    K_MULTI: act = 32'(lk_multi);
                    K_VIC:   act = 32'(victim_idx);
                    default: act = pr_addr;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic lookup(input logic [VPN_W-1:0] v, input string t);
        logic [ENTRIES-1:0] mv = '0;
        logic [PPN_W-1:0]   pp = '0;
        @(negedge clk);
        lk_vpn = v;
        for (int i = 0; i < ENTRIES; i++)
            if (m_valid[i] && m_vpn[i] == v) begin
                mv[i] = 1'b1;
                pp |= m_ppn[i];
            end
        push(K_HIT, 32'(|mv), t);
        push(K_MATCH, 32'(mv), t);
        push(K_MULTI, 32'($countones(mv) > 1), t);
        if (|mv) push(K_PPN, 32'(pp), t);
    endtask

    task automatic model_fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
        m_valid[m_ptr] = 1'b1; m_vpn[m_ptr] = v; m_ppn[m_ptr] = p;
        m_ptr = (m_ptr + 1) % ENTRIES;
    endtask

    task automatic do_write(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
        @(negedge clk);
        wr_en = 1'b1; wr_vpn = v; wr_ppn = p;
        @(negedge clk);
        wr_en = 1'b0;
        model_fill(v, p);
        push(K_VIC, 32'(m_ptr), "R2");
    endtask

    task automatic do_inv_one(input logic [VPN_W-1:0] k, input bit w,
                              input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
        @(negedge clk);
        inv_one = 1'b1; inv_vpn = k; wr_en = w; wr_vpn = v; wr_ppn = p;
        @(negedge clk);
        inv_one = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            if (m_vpn[i] == k) m_valid[i] = 1'b0;
        if (w) model_fill(v, p);
        push(K_VIC, 32'(m_ptr), "R3");
    endtask

    task automatic do_flush_with_write(input logic [VPN_W-1:0] v);
        @(negedge clk);
        inv_all = 1'b1; wr_en = 1'b1; wr_vpn = v; wr_ppn = 20'h7777;
        @(negedge clk);
        inv_all = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < ENTRIES; i++) m_valid[i] = 1'b0;
        push(K_VIC, 32'(m_ptr), "R5");
    endtask

    task automatic do_probe(input bit bw, input logic [PA_W-1:0] b, input bit st,
                            input logic [VPN_W-1:0] v, input bit rt, input string t);
        @(negedge clk);
        base_we = bw; base_val = b; pr_start = st; pr_vpn = v; pr_retry = rt;
        @(negedge clk);
        base_we = 1'b0; pr_start = 1'b0; pr_retry = 1'b0;
        if (bw) m_base = b;
        if (st) m_idx = hash_ref(v);
        else if (rt) m_idx = m_idx + 1'b1;
        push(K_ADDR, m_base + (PA_W'(m_idx) << TSHIFT), t);
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state
        lookup(20'h00000, "R7");
        push(K_VIC, 32'd0, "R7");
        push(K_ADDR, 32'd0, "R7");

        // R1, R2: fill and look up
        do_write(20'h00011, 20'hA0001);
        do_write(20'h00022, 20'hA0002);
        do_write(20'h00033, 20'hA0003);
        do_write(20'h12345, 20'hBEEF1);
        lookup(20'h00011, "R1");
        lookup(20'h00022, "R1");
        lookup(20'h12345, "R1");
        lookup(20'h00044, "R1");

        // R2: pointer wraps, oldest slot is evicted
        for (int i = 4; i < ENTRIES; i++)
            do_write(20'(32'h100 + i), 20'(32'h200 + i));
        do_write(20'h00055, 20'h55555);
        lookup(20'h00011, "R2");
        lookup(20'h00055, "R2");
        lookup(20'h0010F, "R2");

        // R3: lookups and an unmatched invalidate leave the pointer alone
        lookup(20'h00033, "R3");
        lookup(20'h00099, "R3");
        do_inv_one(20'h00777, 1'b0, '0, '0);
        lookup(20'h00022, "R3");

        // R4: duplicate page raises the multi flag, pages OR together
        do_write(20'h00033, 20'h0F0F0);
        lookup(20'h00033, "R4");

        // R6: per-page invalidate, alone and racing a write
        do_inv_one(20'h00033, 1'b0, '0, '0);
        lookup(20'h00033, "R6");
        lookup(20'h12345, "R6");
        do_inv_one(20'h12345, 1'b1, 20'h12345, 20'h33333);
        lookup(20'h12345, "R6");
        lookup(20'h00055, "R6");

        // R5: flush beats a same-cycle write
        do_flush_with_write(20'h00999);
        lookup(20'h00999, "R5");
        lookup(20'h00055, "R5");
        lookup(20'h00104, "R5");

        // R10, R8, R9: probe address generation
        do_probe(1'b1, 32'h4000_0000, 1'b0, '0, 1'b0, "R10");
        do_probe(1'b0, '0, 1'b1, 20'h12345, 1'b0, "R8");
        do_probe(1'b0, '0, 1'b0, '0, 1'b1, "R9");
        do_probe(1'b0, '0, 1'b0, '0, 1'b1, "R9");
        do_probe(1'b0, '0, 1'b1, 20'h000FF, 1'b1, "R9");
        do_probe(1'b0, '0, 1'b0, '0, 1'b1, "R9");
        do_probe(1'b1, 32'hFFFF_FFF8, 1'b1, 20'hABCDE, 1'b0, "R8");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule